// File: doc/BRIEF.md
# Bank-switched dual-port memory

This block is a two-port storage array divided into four equal banks. Each bank is owned by exactly one port at any time, and an external select line per bank says which. A select value of 0 gives the bank to the left port and 1 gives it to the right port. The two ports run side by side with no arbitration. A port can touch only the banks it currently owns, and a request to any other bank is rejected.

Each port has an active-low and an active-high chip select, a write strobe, an output enable, and upper and lower byte-lane enables. A port addresses a word with a bank number followed by an offset inside that bank. The model is synchronous. Requests are sampled on the rising clock edge, and read data comes out one clock later. The bank depth and the word width are parameters. The ownership lines are registered, so a change of ownership takes effect at the next edge.

Top module: `bsdp_mem`

## Requirements
- R1: After reset, with both ports idle, each port shows `*_rdata` = 0, `*_dout_en` = 0 and `*_err` = 0.
- R2: A write (`*_wr_n` = 0) to an owned bank stores `*_wdata[15:8]` only when `*_hi_n` = 0 and `*_wdata[7:0]` only when `*_lo_n` = 0. A byte lane that is not enabled keeps its previous contents.
- R3: A read (`*_rd_n` = 0 with `*_wr_n` = 1) to an owned bank sets `*_dout_en` = 1 one clock after the request. `*_rdata` then returns the stored word, with any lane whose byte enable was deasserted returned as zero.
- R4: A port is enabled only when `*_cs_n` = 0 and `*_cs` = 1. When it is not enabled, it neither writes nor reads, and on the following cycle it shows `*_dout_en` = 0, `*_rdata` = 0 and `*_err` = 0.
- R5: `bank_to_r[i]` = 0 gives bank i to the left port and 1 gives it to the right port. A read or write to a bank the port does not own changes no storage. One clock later that port shows `*_err` = 1 for one cycle, with `*_rdata` = 0.
- R6: A change on `bank_to_r` takes effect at the next rising edge. A request sampled at that same edge is judged against the previous ownership.
- R7: The two ports may each access a bank they own in the same cycle, and neither access disturbs the other.
- R8: A word is addressed by the bank number `*_bank` plus the offset `*_ofs`. The same offset in two different banks names two separate words.
- R9: An enabled port with `*_rd_n` = 1, or with `*_wr_n` = 0, shows `*_dout_en` = 0 and `*_rdata` = 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_to_r | input | NUM_BANKS | Per-bank owner select, 1 = right port |
| l_cs_n | input | 1 | Left chip select, active low |
| l_cs | input | 1 | Left chip select, active high |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_rd_n | input | 1 | Left output enable, active low |
| l_hi_n | input | 1 | Left upper byte enable, active low |
| l_lo_n | input | 1 | Left lower byte enable, active low |
| l_bank | input | BANK_W | Left bank number |
| l_ofs | input | OFS_W | Left offset within the bank |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_dout_en | output | 1 | Left read data valid / driven |
| l_err | output | 1 | Left access to an unowned bank |
| r_cs_n | input | 1 | Right chip select, active low |
| r_cs | input | 1 | Right chip select, active high |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_rd_n | input | 1 | Right output enable, active low |
| r_hi_n | input | 1 | Right upper byte enable, active low |
| r_lo_n | input | 1 | Right lower byte enable, active low |
| r_bank | input | BANK_W | Right bank number |
| r_ofs | input | OFS_W | Right offset within the bank |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_dout_en | output | 1 | Right read data valid / driven |
| r_err | output | 1 | Right access to an unowned bank |

## Verification
A change of ownership and an access to the bank being handed over can fall in the same cycle. The bench provokes this by raising a bank's select line in the same cycle that the right port reads that bank. It expects an error pulse, because the old owner still holds the bank at that edge. It then repeats the read and expects the stored word, and at the same moment the left port, which has just lost the bank, is expected to see an error. The bench also issues writes, and then reads, from both ports in one cycle to two banks owned by different sides, and checks that each port gets its own data back.

// File: rtl/bsdp_pkg.sv
package bsdp_pkg;
  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  localparam int LANES = 2;
endpackage

// File: rtl/bsdp_port.sv
module bsdp_port
  import bsdp_pkg::*;
#(
  parameter side_e SIDE      = SIDE_L,
  parameter int    NUM_BANKS = 4,
  parameter int    DATA_W    = 16,
  parameter int    OFS_W     = 8,
  localparam int   BANK_W    = $clog2(NUM_BANKS),
  localparam int   BYTE_W    = DATA_W / LANES
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cs_n,
  input  logic                              cs,
  input  logic                              wr_n,
  input  logic                              rd_n,
  input  logic                              hi_n,
  input  logic                              lo_n,
  input  logic [BANK_W-1:0]                 bank,
  input  logic [NUM_BANKS-1:0]              own_q,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_rd,
  output logic                              wr_ok,
  output logic                              rd_ok,
  output logic [LANES-1:0]                  be,
  output logic [DATA_W-1:0]                 rdata,
  output logic                              dout_en,
  output logic                              err
);
  logic              en, wr, rd, owned, err_d;
  logic              rd_v_q, rd_hit_q, err_q;
  logic [BANK_W-1:0] bank_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] lane_mask;

  // request decode
  always_comb begin
    en    = !cs_n && cs;
    wr    = en && !wr_n;
    rd    = en && wr_n && !rd_n;
    owned = (own_q[bank] == 1'(SIDE));
    wr_ok = wr && owned;
    rd_ok = rd && owned;
    err_d = (wr || rd) && !owned;
    be    = {!hi_n, !lo_n};
  end

  // response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v_q   <= 1'b0;
      rd_hit_q <= 1'b0;
      err_q    <= 1'b0;
      bank_q   <= '0;
      be_q     <= '0;
    end else begin
      rd_v_q   <= rd;
      rd_hit_q <= rd_ok;
      err_q    <= err_d;
      if (rd_ok) begin
        bank_q <= bank;
        be_q   <= be;
      end
    end
  end

  always_comb begin
    lane_mask = {{BYTE_W{be_q[1]}}, {BYTE_W{be_q[0]}}};
    rdata     = rd_hit_q ? (bank_rd[bank_q] & lane_mask) : '0;
    dout_en   = rd_v_q;
    err       = err_q;
  end
endmodule

// File: rtl/bsdp_bank.sv
module bsdp_bank
  import bsdp_pkg::*;
#(
  parameter int  IDX       = 0,
  parameter int  NUM_BANKS = 4,
  parameter int  DATA_W    = 16,
  parameter int  DEPTH     = 256,
  localparam int OFS_W     = $clog2(DEPTH),
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int BYTE_W    = DATA_W / LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_wr_ok,
  input  logic              l_rd_ok,
  input  logic [BANK_W-1:0] l_bank,
  input  logic [OFS_W-1:0]  l_ofs,
  input  logic [LANES-1:0]  l_be,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              r_wr_ok,
  input  logic              r_rd_ok,
  input  logic [BANK_W-1:0] r_bank,
  input  logic [OFS_W-1:0]  r_ofs,
  input  logic [LANES-1:0]  r_be,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] rd_q
);
  logic              l_sel, r_sel, wr_en, rd_en;
  logic [OFS_W-1:0]  ofs;
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] mem [DEPTH];

  // ownership already qualified the requests, so at most one side hits
  always_comb begin
    l_sel = (l_wr_ok || l_rd_ok) && (l_bank == BANK_W'(IDX));
    r_sel = (r_wr_ok || r_rd_ok) && (r_bank == BANK_W'(IDX));
    if (r_sel) begin
      wr_en = r_wr_ok;
      rd_en = r_rd_ok;
      ofs   = r_ofs;
      be    = r_be;
      wdata = r_wdata;
    end else begin
      wr_en = l_sel && l_wr_ok;
      rd_en = l_sel && l_rd_ok;
      ofs   = l_ofs;
      be    = l_be;
      wdata = l_wdata;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && be[g]) begin
        mem[ofs][g*BYTE_W +: BYTE_W] <= wdata[g*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= mem[ofs];
    end
  end
endmodule

// File: rtl/bsdp_mem.sv
module bsdp_mem
  import bsdp_pkg::*;
#(
  parameter int  NUM_BANKS  = 4,
  parameter int  DATA_W     = 16,
  parameter int  BANK_DEPTH = 256,
  localparam int OFS_W      = $clog2(BANK_DEPTH),
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_to_r,
  input  logic                 l_cs_n,
  input  logic                 l_cs,
  input  logic                 l_wr_n,
  input  logic                 l_rd_n,
  input  logic                 l_hi_n,
  input  logic                 l_lo_n,
  input  logic [BANK_W-1:0]    l_bank,
  input  logic [OFS_W-1:0]     l_ofs,
  input  logic [DATA_W-1:0]    l_wdata,
  output logic [DATA_W-1:0]    l_rdata,
  output logic                 l_dout_en,
  output logic                 l_err,
  input  logic                 r_cs_n,
  input  logic                 r_cs,
  input  logic                 r_wr_n,
  input  logic                 r_rd_n,
  input  logic                 r_hi_n,
  input  logic                 r_lo_n,
  input  logic [BANK_W-1:0]    r_bank,
  input  logic [OFS_W-1:0]     r_ofs,
  input  logic [DATA_W-1:0]    r_wdata,
  output logic [DATA_W-1:0]    r_rdata,
  output logic                 r_dout_en,
  output logic                 r_err
);
  logic                             rst_meta_n, rst_sync_n;
  logic [NUM_BANKS-1:0]             own_q;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;
  logic                             l_wr_ok, l_rd_ok, r_wr_ok, r_rd_ok;
  logic [LANES-1:0]                 l_be, r_be;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // ownership register: new selects apply from the next edge
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      own_q <= '0;
    end else begin
      own_q <= bank_to_r;
    end
  end

  bsdp_port #(.SIDE(SIDE_L), .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_port_l (
    .clk(clk), .rst_n(rst_sync_n),
    .cs_n(l_cs_n), .cs(l_cs), .wr_n(l_wr_n), .rd_n(l_rd_n), .hi_n(l_hi_n), .lo_n(l_lo_n),
    .bank(l_bank), .own_q(own_q), .bank_rd(bank_rd),
    .wr_ok(l_wr_ok), .rd_ok(l_rd_ok), .be(l_be),
    .rdata(l_rdata), .dout_en(l_dout_en), .err(l_err)
  );

  bsdp_port #(.SIDE(SIDE_R), .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_port_r (
    .clk(clk), .rst_n(rst_sync_n),
    .cs_n(r_cs_n), .cs(r_cs), .wr_n(r_wr_n), .rd_n(r_rd_n), .hi_n(r_hi_n), .lo_n(r_lo_n),
    .bank(r_bank), .own_q(own_q), .bank_rd(bank_rd),
    .wr_ok(r_wr_ok), .rd_ok(r_rd_ok), .be(r_be),
    .rdata(r_rdata), .dout_en(r_dout_en), .err(r_err)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bsdp_bank #(.IDX(b), .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_sync_n),
      .l_wr_ok(l_wr_ok), .l_rd_ok(l_rd_ok), .l_bank(l_bank), .l_ofs(l_ofs),
      .l_be(l_be), .l_wdata(l_wdata),
      .r_wr_ok(r_wr_ok), .r_rd_ok(r_rd_ok), .r_bank(r_bank), .r_ofs(r_ofs),
      .r_be(r_be), .r_wdata(r_wdata),
      .rd_q(bank_rd[b])
    );
  end
endmodule

// File: rtl/bsdp_mem_chk.sv
module bsdp_mem_chk #(
  parameter int  NUM_BANKS = 4,
  parameter int  DATA_W    = 16,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] own_q,
  input logic [NUM_BANKS-1:0] bank_to_r,
  input logic                 l_cs_n, l_cs, l_wr_n, l_rd_n,
  input logic [BANK_W-1:0]    l_bank,
  input logic [DATA_W-1:0]    l_rdata,
  input logic                 l_dout_en, l_err,
  input logic                 r_cs_n, r_cs, r_wr_n, r_rd_n,
  input logic [BANK_W-1:0]    r_bank,
  input logic [DATA_W-1:0]    r_rdata,
  input logic                 r_dout_en, r_err
);
  logic ok_q;
  logic l_en, r_en, l_rdreq, r_rdreq, l_acc, r_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= 1'b1;
  end

  always_comb begin
    l_en    = !l_cs_n && l_cs;
    r_en    = !r_cs_n && r_cs;
    l_rdreq = l_en && l_wr_n && !l_rd_n;
    r_rdreq = r_en && r_wr_n && !r_rd_n;
    l_acc   = l_en && (!l_wr_n || !l_rd_n);
    r_acc   = r_en && (!r_wr_n || !r_rd_n);
  end

  // R6
  own_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> own_q == $past(bank_to_r));
  // R3
  l_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q && l_dout_en) |-> $past(l_rdreq));
  // R3
  r_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q && r_dout_en) |-> $past(r_rdreq));
  // R9
  l_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_dout_en |-> l_rdata == '0);
  // R9
  r_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_dout_en |-> r_rdata == '0);
  // R5
  l_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_err |-> l_rdata == '0);
  // R5
  r_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_err |-> r_rdata == '0);
  // R5
  l_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q && l_err) |-> $past(l_acc && own_q[l_bank]));
  // R5
  r_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q && r_err) |-> $past(r_acc && !own_q[r_bank]));
  // R4
  l_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q && $past(!l_en)) |-> (!l_dout_en && !l_err));
  // R4
  r_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q && $past(!r_en)) |-> (!r_dout_en && !r_err));
endmodule

bind bsdp_mem bsdp_mem_chk #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .own_q(own_q), .bank_to_r(bank_to_r),
  .l_cs_n(l_cs_n), .l_cs(l_cs), .l_wr_n(l_wr_n), .l_rd_n(l_rd_n), .l_bank(l_bank),
  .l_rdata(l_rdata), .l_dout_en(l_dout_en), .l_err(l_err),
  .r_cs_n(r_cs_n), .r_cs(r_cs), .r_wr_n(r_wr_n), .r_rd_n(r_rd_n), .r_bank(r_bank),
  .r_rdata(r_rdata), .r_dout_en(r_dout_en), .r_err(r_err)
);

// File: tb/bsdp_mem_tb.sv
`timescale 1ns/1ps
module bsdp_mem_tb;
  localparam int NB = 4, DW = 16, DEPTH = 256, OW = $clog2(DEPTH), BW = $clog2(NB);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NB-1:0] bank_to_r;
  logic l_cs_n, l_cs, l_wr_n, l_rd_n, l_hi_n, l_lo_n;
  logic [BW-1:0] l_bank;  logic [OW-1:0] l_ofs;  logic [DW-1:0] l_wdata, l_rdata;
  logic l_dout_en, l_err;
  logic r_cs_n, r_cs, r_wr_n, r_rd_n, r_hi_n, r_lo_n;
  logic [BW-1:0] r_bank;  logic [OW-1:0] r_ofs;  logic [DW-1:0] r_wdata, r_rdata;
  logic r_dout_en, r_err;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bsdp_mem #(.NUM_BANKS(NB), .DATA_W(DW), .BANK_DEPTH(DEPTH)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cs: 1=enable, wr/rd active high here, be = {hi,lo}
  task automatic set_l(bit cs, bit wr, bit rd, bit [1:0] be, int bk, int ofs, logic [DW-1:0] wd);
    l_cs_n = !cs; l_cs = cs; l_wr_n = !wr; l_rd_n = !rd;
    l_hi_n = !be[1]; l_lo_n = !be[0]; l_bank = BW'(bk); l_ofs = OW'(ofs); l_wdata = wd;
  endtask
  task automatic set_r(bit cs, bit wr, bit rd, bit [1:0] be, int bk, int ofs, logic [DW-1:0] wd);
    r_cs_n = !cs; r_cs = cs; r_wr_n = !wr; r_rd_n = !rd;
    r_hi_n = !be[1]; r_lo_n = !be[0]; r_bank = BW'(bk); r_ofs = OW'(ofs); r_wdata = wd;
  endtask
  task automatic idle();
    set_l(0, 0, 0, 2'b00, 0, 0, '0);
    set_r(0, 0, 0, 2'b00, 0, 0, '0);
  endtask
  // apply current inputs at one edge, land on the next falling edge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask
  task automatic cycle_then_idle();
    step(); idle();
  endtask

  task automatic t_reset();
    check("R1 l_rdata", l_rdata, 0);   check("R1 l_dout_en", l_dout_en, 0);
    check("R1 l_err", l_err, 0);       check("R1 r_rdata", r_rdata, 0);
    check("R1 r_dout_en", r_dout_en, 0); check("R1 r_err", r_err, 0);
  endtask

  task automatic t_write_read();
    bank_to_r = 4'b0000; step();
    set_l(1, 1, 0, 2'b11, 0, 5, 16'hA5C3); step();
    check("R9 write gives no dout_en", l_dout_en, 0);
    check("R9 write gives zero rdata", l_rdata, 0);
    set_l(1, 1, 0, 2'b11, 1, 5, 16'h1234); cycle_then_idle();
    set_l(1, 0, 1, 2'b11, 0, 5, '0); step();
    check("R3 read dout_en", l_dout_en, 1);
    check("R8 bank0 word", l_rdata, 16'hA5C3);
    set_l(1, 0, 1, 2'b11, 1, 5, '0); step();
    check("R8 bank1 same offset", l_rdata, 16'h1234);
    idle(); step();
    check("R3 dout_en drops", l_dout_en, 0);
  endtask

  task automatic t_byte_lanes();
    set_l(1, 1, 0, 2'b10, 0, 5, 16'hFF00); cycle_then_idle();
    set_l(1, 0, 1, 2'b11, 0, 5, '0); step();
    check("R2 upper lane only", l_rdata, 16'hFFC3);
    set_l(1, 0, 1, 2'b01, 0, 5, '0); step();
    check("R3 lower lane read", l_rdata, 16'h00C3);
    set_l(1, 0, 1, 2'b10, 0, 5, '0); step();
    check("R3 upper lane read", l_rdata, 16'hFF00);
    idle(); step();
  endtask

  task automatic t_chip_enable();
    // cs_n high, cs high: disabled
    set_l(0, 1, 0, 2'b11, 0, 5, 16'h0000); l_cs = 1'b1; cycle_then_idle();
    // cs_n low, cs low: disabled
    set_l(1, 1, 0, 2'b11, 0, 5, 16'h0000); l_cs = 1'b0; cycle_then_idle();
    set_l(1, 0, 1, 2'b11, 0, 5, '0); l_cs_n = 1'b1; step();
    check("R4 disabled read dout_en", l_dout_en, 0);
    check("R4 disabled read rdata", l_rdata, 0);
    check("R4 disabled err", l_err, 0);
    set_l(1, 0, 1, 2'b11, 0, 5, '0); step();
    check("R4 disabled writes ignored", l_rdata, 16'hFFC3);
    set_l(1, 0, 0, 2'b11, 0, 5, '0); step();
    check("R9 oe off dout_en", l_dout_en, 0);
    check("R9 oe off rdata", l_rdata, 0);
    idle(); step();
  endtask

  task automatic t_ownership();
    set_r(1, 0, 1, 2'b11, 1, 5, '0); step();
    check("R5 unowned read err", r_err, 1);
    check("R5 unowned read rdata", r_rdata, 0);
    set_r(1, 1, 0, 2'b11, 1, 5, 16'hDEAD); step();
    check("R5 err held by new bad write", r_err, 1);
    idle(); step();
    check("R5 err one cycle", r_err, 0);
    set_l(1, 0, 1, 2'b11, 1, 5, '0); step();
    check("R5 unowned write ignored", l_rdata, 16'h1234);
    check("R5 owner no err", l_err, 0);
    idle(); step();
  endtask

  task automatic t_switch();
    bank_to_r = 4'b0001;
    set_r(1, 0, 1, 2'b11, 0, 5, '0); step();
    check("R6 same-cycle access uses old owner", r_err, 1);
    check("R6 old owner rdata zero", r_rdata, 0);
    set_r(1, 0, 1, 2'b11, 0, 5, '0);
    set_l(1, 0, 1, 2'b11, 0, 5, '0); step();
    check("R6 new owner reads", r_rdata, 16'hFFC3);
    check("R6 new owner no err", r_err, 0);
    check("R6 old owner now blocked", l_err, 1);
    idle(); step();
  endtask

  task automatic t_concurrent();
    bank_to_r = 4'b1100; step();
    set_l(1, 1, 0, 2'b11, 1, 7, 16'h0F0F);
    set_r(1, 1, 0, 2'b11, 2, 7, 16'h7777); cycle_then_idle();
    set_l(1, 0, 1, 2'b11, 1, 7, '0);
    set_r(1, 0, 1, 2'b11, 2, 7, '0); step();
    check("R7 left concurrent read", l_rdata, 16'h0F0F);
    check("R7 right concurrent read", r_rdata, 16'h7777);
    check("R7 left no err", l_err, 0);
    check("R7 right no err", r_err, 0);
    idle(); step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bank_to_r = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_read();
    t_byte_lanes();
    t_chip_enable();
    t_ownership();
    t_switch();
    t_concurrent();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule